// File: doc/BRIEF.md
# Delay Window Search Sequencer

This block calibrates a memory interface by sweeping three delay settings in nested loops: a read-strobe delay (outer loop, driven identically onto four byte lanes), a strobe output delay (middle loop) and a write-strobe delay (inner loop). For every combination it asks an external test engine to run a pattern test through a start/done/fail handshake. From the results it finds the widest contiguous band of passing inner values and the longest run of outer steps whose inner band is wide enough. It then drives the centre of each band onto the delay outputs.

Once the final settings are applied, the sequencer requests one more test as a check. It then reports done or fail. It also supplies a test address that steps through memory after every sweep test and wraps at the memory size. A calibration begins with a one-cycle start pulse. Busy stays high until the result is known.

Top module: `delay_window_search`

## Requirements
- R1: After reset busy, done, fail and testStart are low and testAddr equals INIT_ADDR (0xFF00).
- R2: A start pulse while idle begins a sweep that issues exactly one test per combination: outer value OUT_LO..OUT_HI (slowest), middle MID_LO..MID_HI, inner IN_LO..IN_HI (fastest), each ascending. Each value is on its output while its test is requested.
- R3: Every lane slice rdLaneDly[8k+7:8k] (k = 0..3) carries the same outer value.
- R4: The first sweep test uses address INIT_ADDR. After each sweep test response the address becomes (addr + 0x20000) & (memSize - 1), where memSize is a power of two. The verification test uses the address reached after the last sweep response.
- R5: testStart is a one-cycle pulse. No new request follows until testDone (with testFail high meaning failure) has been returned, and the delay outputs and testAddr hold while a test is outstanding.
- R6: Within one middle value, a pass with no open window opens a window at the current inner value. A fail while a window is open closes it with end = the failing value. The window replaces the step's best only if end - start is strictly greater, and the middle value is recorded with it. A window still open at the end of the inner sweep is dropped. A start of zero means no window.
- R7: An outer step is accepted when its best inner width exceeds 5. A run of accepted steps opens at the first accepted step and closes at the next non-accepted step (end = that step). It replaces the best run only if strictly longer. A run still open after the last step is dropped.
- R8: The widest step best over all outer steps, with its middle value, is kept as the final configuration, replaced only on strictly greater width.
- R9: If the final inner width is below 5, fail is raised without a verification test.
- R10: Otherwise the outputs become outer = (runStart + runEnd) >> 1, middle = the stored middle value, inner = (winStart + winEnd) >> 1, and one verification test is requested.
- R11: A verification pass raises done and a failure raises fail. busy stays high until then. done and fail hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a calibration when idle |
| memSize | input | ADDR_W | Memory size in bytes, power of two |
| testDone | input | 1 | Test engine finished the requested test |
| testFail | input | 1 | Qualifies testDone: test failed |
| testStart | output | 1 | One-cycle test request |
| testAddr | output | ADDR_W | Address offset for the requested test |
| rdLaneDly | output | LANES*DW | Read-strobe delay, one copy per byte lane |
| strobeOutDly | output | DW | Strobe output delay |
| wrStrobeDly | output | DW | Write-strobe delay |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished and verified |
| fail | output | 1 | Calibration failed |

## Verification
The hardest situations to reach are the tie and drop cases of the window rules. These are a window still open at the end of a sweep, an accepted run that never closes, and a second window of equal width that must not replace the first. Reaching them needs a whole pass/fail map over the three settings. The bench builds such maps from seeded random window placements and adds trailing open windows. It also uses directed maps: every test passing, where no window ever closes, and every outer step accepted, where the run never closes and the outer result falls to zero. It answers each request from the map after a random latency.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef struct packed {
    logic clrAll;
    logic takeResult;
    logic stepEval;
    logic applyFinal;
  } dwsCtlT;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_STEP, S_CHECK, S_VISSUE, S_VWAIT
  } dwsStateT;
endpackage

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   testDone,
  input  logic   testFail,
  input  logic   innerLast,
  input  logic   midLast,
  input  logic   outerLast,
  input  logic   cfgNarrow,
  output dwsCtlT ctl,
  output logic   testStart,
  output logic   busy,
  output logic   done,
  output logic   fail
);
  dwsStateT state, nxt;

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      S_IDLE:   if (start) begin ctl.clrAll = 1'b1; nxt = S_ISSUE; end
      S_ISSUE:  nxt = S_WAIT;
      S_WAIT:   if (testDone) begin
                  ctl.takeResult = 1'b1;
                  nxt = (innerLast && midLast) ? S_STEP : S_ISSUE;
                end
      S_STEP:   begin ctl.stepEval = 1'b1; nxt = outerLast ? S_CHECK : S_ISSUE; end
      S_CHECK:  if (cfgNarrow) nxt = S_IDLE;
                else begin ctl.applyFinal = 1'b1; nxt = S_VISSUE; end
      S_VISSUE: nxt = S_VWAIT;
      S_VWAIT:  if (testDone) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        done <= 1'b0;
        fail <= 1'b0;
      end
      if (state == S_CHECK && cfgNarrow) fail <= 1'b1;
      if (state == S_VWAIT && testDone) begin
        done <= !testFail;
        fail <= testFail;
      end
    end
  end

  assign testStart = (state == S_ISSUE) || (state == S_VISSUE);
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/dws_dpath.sv
module dws_dpath
  import dws_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ADDR_W    = 32,
  parameter int OUT_LO    = 'h09,
  parameter int OUT_HI    = 'h30,
  parameter int MID_LO    = 'h55,
  parameter int MID_HI    = 'h75,
  parameter int IN_LO     = 'h30,
  parameter int IN_HI     = 'h60,
  parameter int MIN_WIN   = 5,
  parameter int ADDR_STEP = 'h20000,
  parameter int INIT_ADDR = 'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwsCtlT            ctl,
  input  logic              testFail,
  input  logic [ADDR_W-1:0] memSize,
  output logic [DW-1:0]     outerIdx,
  output logic [DW-1:0]     midIdx,
  output logic [DW-1:0]     innerIdx,
  output logic [ADDR_W-1:0] addr,
  output logic              innerLast,
  output logic              midLast,
  output logic              outerLast,
  output logic              cfgNarrow
);
  localparam logic [DW-1:0]     OLO   = DW'(OUT_LO);
  localparam logic [DW-1:0]     MLO   = DW'(MID_LO);
  localparam logic [DW-1:0]     ILO   = DW'(IN_LO);
  localparam logic [ADDR_W-1:0] AINIT = ADDR_W'(INIT_ADDR);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(ADDR_STEP);
  localparam logic [DW-1:0]     MINW  = DW'(MIN_WIN);

  logic [DW-1:0] winStart, stepS, stepE, stepMid;
  logic [DW-1:0] runStart, runS, runE, cfgS, cfgE, cfgMid;
  logic [DW-1:0] stepWidth, cfgWidth, runLen;
  logic [DW:0]   runSum, cfgSum;

  assign stepWidth = stepE - stepS;
  assign cfgWidth  = cfgE - cfgS;
  assign runLen    = runE - runS;
  assign runSum    = {1'b0, runS} + {1'b0, runE};
  assign cfgSum    = {1'b0, cfgS} + {1'b0, cfgE};
  assign innerLast = (innerIdx == DW'(IN_HI));
  assign midLast   = (midIdx == DW'(MID_HI));
  assign outerLast = (outerIdx == DW'(OUT_HI));
  assign cfgNarrow = (cfgWidth < MINW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outerIdx <= '0; midIdx <= '0; innerIdx <= '0; addr <= AINIT;
      winStart <= '0; stepS <= '0; stepE <= '0; stepMid <= '0;
      runStart <= '0; runS <= '0; runE <= '0;
      cfgS <= '0; cfgE <= '0; cfgMid <= '0;
    end else begin
      if (ctl.clrAll) begin
        outerIdx <= OLO; midIdx <= MLO; innerIdx <= ILO; addr <= AINIT;
        winStart <= '0; stepS <= '0; stepE <= '0; stepMid <= '0;
        runStart <= '0; runS <= '0; runE <= '0;
        cfgS <= '0; cfgE <= '0; cfgMid <= '0;
      end
      if (ctl.takeResult) begin
        addr <= (addr + ASTEP) & (memSize - 1'b1);
        if (testFail) begin
          if (winStart != '0) begin
            if ((innerIdx - winStart) > stepWidth) begin
              stepS   <= winStart;
              stepE   <= innerIdx;
              stepMid <= midIdx;
            end
            winStart <= '0;
          end
        end else if (winStart == '0) begin
          winStart <= innerIdx;
        end
        if (innerLast) begin
          innerIdx <= ILO;
          winStart <= '0;
          if (!midLast) midIdx <= midIdx + 1'b1;
        end else begin
          innerIdx <= innerIdx + 1'b1;
        end
      end
      if (ctl.stepEval) begin
        if (stepWidth > MINW) begin
          if (runStart == '0) runStart <= outerIdx;
        end else if (runStart != '0) begin
          if ((outerIdx - runStart) > runLen) begin
            runS <= runStart;
            runE <= outerIdx;
          end
          runStart <= '0;
        end
        if (stepWidth > cfgWidth) begin
          cfgS   <= stepS;
          cfgE   <= stepE;
          cfgMid <= stepMid;
        end
        stepS <= '0; stepE <= '0; stepMid <= '0;
        midIdx <= MLO;
        if (!outerLast) outerIdx <= outerIdx + 1'b1;
      end
      if (ctl.applyFinal) begin
        outerIdx <= runSum[DW:1];
        midIdx   <= cfgMid;
        innerIdx <= cfgSum[DW:1];
      end
    end
  end
endmodule

// File: rtl/delay_window_search.sv
module delay_window_search
  import dws_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LANES     = 4,
  parameter int ADDR_W    = 32,
  parameter int OUT_LO    = 'h09,
  parameter int OUT_HI    = 'h30,
  parameter int MID_LO    = 'h55,
  parameter int MID_HI    = 'h75,
  parameter int IN_LO     = 'h30,
  parameter int IN_HI     = 'h60,
  parameter int MIN_WIN   = 5,
  parameter int ADDR_STEP = 'h20000,
  parameter int INIT_ADDR = 'hFF00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ADDR_W-1:0]   memSize,
  input  logic                testDone,
  input  logic                testFail,
  output logic                testStart,
  output logic [ADDR_W-1:0]   testAddr,
  output logic [LANES*DW-1:0] rdLaneDly,
  output logic [DW-1:0]       strobeOutDly,
  output logic [DW-1:0]       wrStrobeDly,
  output logic                busy,
  output logic                done,
  output logic                fail
);
  dwsCtlT        ctl;
  logic          innerLast, midLast, outerLast, cfgNarrow;
  logic [DW-1:0] outerIdx;

  dws_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .testDone(testDone), .testFail(testFail),
    .innerLast(innerLast), .midLast(midLast), .outerLast(outerLast), .cfgNarrow(cfgNarrow),
    .ctl(ctl), .testStart(testStart), .busy(busy), .done(done), .fail(fail)
  );

  dws_dpath #(
    .DW(DW), .ADDR_W(ADDR_W), .OUT_LO(OUT_LO), .OUT_HI(OUT_HI), .MID_LO(MID_LO),
    .MID_HI(MID_HI), .IN_LO(IN_LO), .IN_HI(IN_HI), .MIN_WIN(MIN_WIN),
    .ADDR_STEP(ADDR_STEP), .INIT_ADDR(INIT_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .testFail(testFail), .memSize(memSize),
    .outerIdx(outerIdx), .midIdx(strobeOutDly), .innerIdx(wrStrobeDly), .addr(testAddr),
    .innerLast(innerLast), .midLast(midLast), .outerLast(outerLast), .cfgNarrow(cfgNarrow)
  );

  assign rdLaneDly = {LANES{outerIdx}};
endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
  parameter int DW     = 8,
  parameter int LANES  = 4,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                testDone,
  input logic                testStart,
  input logic [ADDR_W-1:0]   testAddr,
  input logic [LANES*DW-1:0] rdLaneDly,
  input logic [DW-1:0]       strobeOutDly,
  input logic [DW-1:0]       wrStrobeDly,
  input logic                busy,
  input logic                done,
  input logic                fail
);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);
  // R5
  hold_settings_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> $stable({rdLaneDly, strobeOutDly, wrStrobeDly, testAddr}));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !testDone) |=> $stable(testAddr));
  // R11
  done_after_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(testDone));
  // R11
  idle_when_finished_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail) |-> !busy);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

bind delay_window_search dws_chk #(.DW(DW), .LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .testDone(testDone), .testStart(testStart),
  .testAddr(testAddr), .rdLaneDly(rdLaneDly), .strobeOutDly(strobeOutDly),
  .wrStrobeDly(wrStrobeDly), .busy(busy), .done(done), .fail(fail)
);

// File: tb/sim_delay_window_search.sv
module sim_delay_window_search;
  localparam int CLK_PERIOD = 10;
  localparam int OLO = 1, OHI = 8, MLO = 2, MHI = 4, ILO = 1, IHI = 14;
  localparam int DW = 8, LANES = 4, AW = 32;
  localparam int LIMIT = 3000;

  logic clk = 0, rstN = 0, start = 0, testDone = 0, testFail = 0;
  logic [AW-1:0] memSize = 32'h0010_0000;
  logic testStart, busy, done, fail;
  logic [AW-1:0] testAddr;
  logic [LANES*DW-1:0] rdLaneDly;
  logic [DW-1:0] strobeOutDly, wrStrobeDly;

  int nChk = 0, nFail = 0;
  bit abortRun;
  bit passMap [OLO:OHI][MLO:MHI][ILO:IHI];
  int expOuter, expMid, expInner;
  bit expNarrow;

  always #(CLK_PERIOD/2) clk = ~clk;

  delay_window_search #(
    .DW(DW), .LANES(LANES), .ADDR_W(AW), .OUT_LO(OLO), .OUT_HI(OHI),
    .MID_LO(MLO), .MID_HI(MHI), .IN_LO(ILO), .IN_HI(IHI)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .memSize(memSize), .testDone(testDone),
    .testFail(testFail), .testStart(testStart), .testAddr(testAddr), .rdLaneDly(rdLaneDly),
    .strobeOutDly(strobeOutDly), .wrStrobeDly(wrStrobeDly), .busy(busy), .done(done), .fail(fail)
  );

  task automatic chk(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkSettings(string req, int o, int m, int i, longint a);
    for (int k = 0; k < LANES; k++) chk({req, " R3 lane"}, rdLaneDly[k*DW +: DW], o);
    chk({req, " outer"}, rdLaneDly[DW-1:0], o);
    chk({req, " middle"}, strobeOutDly, m);
    chk({req, " inner"}, wrStrobeDly, i);
    chk("R4 address", testAddr, a);
  endtask

  // Expected result from the window rules R6, R7, R8, R10
  task automatic computeExpected();
    int rs = 0, rbS = 0, rbE = 0, cS = 0, cE = 0, cM = 0;
    for (int o = OLO; o <= OHI; o++) begin
      int sS = 0, sE = 0, sM = 0;
      for (int m = MLO; m <= MHI; m++) begin
        int ws = 0;
        for (int i = ILO; i <= IHI; i++) begin
          if (!passMap[o][m][i]) begin
            if (ws != 0) begin
              if (i - ws > sE - sS) begin sS = ws; sE = i; sM = m; end
              ws = 0;
            end
          end else if (ws == 0) ws = i;
        end
      end
      if (sE - sS > 5) begin
        if (rs == 0) rs = o;
      end else if (rs != 0) begin
        if (o - rs > rbE - rbS) begin rbS = rs; rbE = o; end
        rs = 0;
      end
      if (sE - sS > cE - cS) begin cS = sS; cE = sE; cM = sM; end
    end
    expNarrow = (cE - cS) < 5;
    expOuter  = (rbS + rbE) >> 1;
    expMid    = cM;
    expInner  = (cS + cE) >> 1;
  endtask

  task automatic waitReq();
    int n = 0;
    while (!testStart && !abortRun) begin
      @(negedge clk);
      n++;
      if (n > LIMIT) begin
        nFail++;
        $display("FAIL R5 watchdog: no request, got 0 expected 1");
        abortRun = 1;
      end
    end
  endtask

  task automatic respond(bit pass);
    repeat (1 + $urandom_range(0, 3)) begin
      @(negedge clk);
      if (testStart) chk("R5 no second request", 1, 0);
    end
    testDone = 1; testFail = !pass;
    @(negedge clk);
    testDone = 0; testFail = 0;
  endtask

  task automatic waitEnd(output int reqs);
    int n = 0;
    reqs = 0;
    while (!(done || fail) && !abortRun) begin
      if (testStart) reqs++;
      @(negedge clk);
      n++;
      if (n > LIMIT) begin
        nFail++;
        $display("FAIL R11 watchdog: no result, got 0 expected 1");
        abortRun = 1;
      end
    end
  endtask

  task automatic runCase(bit verifyPass);
    longint a = 32'hFF00;
    int reqs;
    abortRun = 0;
    computeExpected();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R11 busy after start", busy, 1);
    for (int o = OLO; o <= OHI && !abortRun; o++)
      for (int m = MLO; m <= MHI && !abortRun; m++)
        for (int i = ILO; i <= IHI && !abortRun; i++) begin
          waitReq();
          if (!abortRun) begin
            chkSettings("R2 sweep", o, m, i, a);
            respond(passMap[o][m][i]);
            a = (a + 32'h20000) & (memSize - 1);
          end
        end
    if (abortRun) return;
    if (expNarrow) begin
      waitEnd(reqs);
      chk("R9 no verify request", reqs, 0);
      chk("R9 fail", fail, 1);
      chk("R9 done low", done, 0);
    end else begin
      waitReq();
      if (abortRun) return;
      chkSettings("R10 final", expOuter, expMid, expInner, a);
      chk("R11 busy during verify", busy, 1);
      respond(verifyPass);
      waitEnd(reqs);
      chk("R11 done", done, verifyPass);
      chk("R11 fail", fail, !verifyPass);
      repeat (3) @(negedge clk);
      chk("R11 result held", {done, fail, busy}, {verifyPass, !verifyPass, 1'b0});
    end
  endtask

  task automatic randomMap();
    for (int o = OLO; o <= OHI; o++)
      for (int m = MLO; m <= MHI; m++) begin
        int len, lo;
        for (int i = ILO; i <= IHI; i++) passMap[o][m][i] = 0;
        len = ($urandom_range(0, 99) < 55) ? $urandom_range(6, 10) : $urandom_range(0, 5);
        lo  = $urandom_range(2, IHI - len);
        for (int i = lo; i < lo + len; i++) passMap[o][m][i] = 1;
        // trailing window left open (R6 drop rule)
        if (lo + len + 1 < IHI - 1 && $urandom_range(0, 1) == 1) begin
          passMap[o][m][IHI-1] = 1;
          passMap[o][m][IHI] = 1;
        end
      end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 testStart", testStart, 0);
    chk("R1 addr", testAddr, 32'hFF00);
    rstN = 1;
    @(negedge clk);

    // all pass: every window stays open and is dropped (R6) -> R9 fail
    for (int o = OLO; o <= OHI; o++) for (int m = MLO; m <= MHI; m++)
      for (int i = ILO; i <= IHI; i++) passMap[o][m][i] = 1;
    runCase(1);

    // every step accepted: run never closes (R7) -> outer result 0; equal widths tie (R8)
    for (int o = OLO; o <= OHI; o++) for (int m = MLO; m <= MHI; m++)
      for (int i = ILO; i <= IHI; i++) passMap[o][m][i] = (i >= 3 && i < 10);
    runCase(1);
    chk("R7 open run dropped", rdLaneDly[DW-1:0], 0);

    // random maps, one with failing verification, one with small memory wrap
    randomMap(); runCase(0);
    memSize = 32'h0004_0000;
    randomMap(); runCase(1);
    memSize = 32'h0010_0000;
    for (int r = 0; r < 4; r++) begin randomMap(); runCase(1); end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL global watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule